// File: doc/BRIEF.md
# SYSREF-Phased Extended Multiblock Counter

This block keeps the local extended multiblock phase of a 64b/66b converter link in the link clock domain. It counts link clock cycles from zero up to 32·E−1 and wraps, where E is the number of multiblocks per extended multiblock. A boundary pulse marks each cycle in which the count is zero. Downstream framing logic uses that pulse to place the start of each extended multiblock.

The block has two modes, chosen by a mode input. In free-running mode the count starts on the first clock after link reset is released and never waits for SYSREF. In SYSREF-phased mode the count is held at zero, with a not-aligned status raised, until the first SYSREF rising edge. That edge passes through a two-stage synchronizer and sets the count to zero. Every later SYSREF edge is compared against the running phase. SYSREF may run at any whole-number fraction of the extended multiblock rate, so an edge is expected exactly where the count would have wrapped. An edge at any other phase sets a sticky misalignment flag and re-phases the count.

The block captures E and the mode once, on the first clock edge after reset release. An E of zero is treated as one.

Top module: `xmb_boundary_counter`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0, `not_aligned_o` is 1, and `boundary_o` and `misalign_o` are 0.
- R2: In free-running mode (`mode_sel_i` = 0), the first clock edge after reset release leaves `count_o` at 0 and clears `not_aligned_o`. Each later edge adds one to the count. `sysref_i` has no effect, and `misalign_o` stays 0.
- R3: The count wraps from 32·E−1 to 0, where E is `ext_size_i` read as an unsigned number. An E of 0 behaves as 1.
- R4: `boundary_o` is 1 exactly in the cycles where `count_o` is 0 and `not_aligned_o` is 0.
- R5: `ext_size_i` and `mode_sel_i` are captured on the first clock edge after reset release. Later changes to them have no effect until the next reset.
- R6: In SYSREF-phased mode (`mode_sel_i` = 1), before the first SYSREF rising edge, `count_o` stays 0, `not_aligned_o` stays 1 and `boundary_o` stays 0.
- R7: In SYSREF-phased mode, take the first clock edge at which a rising `sysref_i` is seen high. The count is loaded with 0 and `not_aligned_o` falls at the second edge after it. That edge is the third edge with `sysref_i` high.
- R8: A later SYSREF rising edge that lands where the count would have wrapped to 0 leaves `misalign_o` at 0. This holds at the full extended multiblock rate and at integer fractions of it, such as every second extended multiblock.
- R9: A later SYSREF rising edge at any other phase sets `misalign_o` and loads the count with 0. Counting then continues from that point.
- R10: `misalign_o` stays set until the next reset. Holding `sysref_i` high creates no further edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Link reset: asserts asynchronously, active low, released synchronously |
| sysref_i | input | 1 | Shared SYSREF strobe, asynchronous to the link clock |
| mode_sel_i | input | 1 | 0 selects free-running mode, 1 selects SYSREF-phased mode |
| ext_size_i | input | E_W | Multiblocks per extended multiblock (E) |
| count_o | output | E_W+5 | Current count within the extended multiblock |
| boundary_o | output | 1 | High while the count is at the start of an extended multiblock |
| not_aligned_o | output | 1 | High until the count has been phased |
| misalign_o | output | 1 | Sticky flag for a SYSREF edge seen at the wrong phase |

## Verification
The bench builds the block with E_W = 3, so the count is 8 bits wide and E can be as large as 7. It runs E values of 0, 1, 2 and 3, which reach the wrap points 31, 63 and 95 as well as the guard that maps zero to one. The SYSREF stimulus covers several cases. Some edges arrive at full rate, some at half rate, and some off phase, which sets the misalignment flag. One SYSREF is held high for longer than a whole extended multiblock. Together these exercise the fixed three-edge load latency and the sticky flag under each E.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  // Two-stage synchronizer: keeps the SYSREF load latency at three edges.
  localparam int unsigned XMB_SYNC_STAGES = 2;
  // Each unit of E adds 32 link cycles to the extended multiblock.
  localparam int unsigned XMB_BLK_SHIFT = 5;

  typedef enum logic {
    XMB_FREE_RUN      = 1'b0,
    XMB_SYSREF_PHASED = 1'b1
  } xmb_mode_e;
endpackage

// File: rtl/xmb_sysref_edge.sv
module xmb_sysref_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_comb sync_d[g] = strobe_i;
    end else begin : g_next
      always_comb sync_d[g] = sync_q[g-1];
    end
  end

  always_comb prev_d = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/xmb_cfg_latch.sv
module xmb_cfg_latch
  import xmb_pkg::*;
#(
  parameter int unsigned E_W = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [E_W-1:0] ext_size_i,
  input  xmb_mode_e      mode_i,
  output logic           run_o,
  output logic [E_W-1:0] ext_size_o,
  output xmb_mode_e      mode_o
);
  logic           run_q;
  logic [E_W-1:0] size_q;
  xmb_mode_e      mode_q;
  logic           load_en;

  // Capture is enabled only until the first edge after reset release.
  assign load_en = ~run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      size_q <= '0;
      mode_q <= XMB_FREE_RUN;
    end else if (load_en) begin
      run_q  <= 1'b1;
      size_q <= ext_size_i;
      mode_q <= mode_i;
    end
  end

  // The live inputs pass through during the capture cycle, so the first edge uses them.
  assign run_o      = run_q;
  assign ext_size_o = run_q ? size_q : ext_size_i;
  assign mode_o     = run_q ? mode_q : mode_i;
endmodule

// File: rtl/xmb_phase_count.sv
module xmb_phase_count
  import xmb_pkg::*;
#(
  parameter int unsigned E_W   = 3,
  parameter int unsigned CNT_W = E_W + XMB_BLK_SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [E_W-1:0]   ext_size_i,
  input  xmb_mode_e        mode_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] count_o,
  output logic             locked_o,
  output logic             misalign_o
);
  logic [CNT_W-1:0] count_q, count_d, count_inc, last_idx;
  logic [E_W-1:0]   size_nz;
  logic             locked_q, locked_d;
  logic             mis_q, mis_d;
  logic             at_last;

  always_comb begin
    size_nz   = (ext_size_i == '0) ? E_W'(1) : ext_size_i;
    last_idx  = CNT_W'({size_nz, {XMB_BLK_SHIFT{1'b0}}}) - CNT_W'(1);
    at_last   = (count_q == last_idx);
    count_inc = at_last ? '0 : count_q + CNT_W'(1);
  end

  always_comb begin
    count_d  = count_q;
    locked_d = locked_q;
    mis_d    = mis_q;
    unique case (mode_i)
      XMB_FREE_RUN: begin
        if (locked_q) begin
          count_d = count_inc;
        end else begin
          locked_d = 1'b1;
          count_d  = '0;
        end
      end
      XMB_SYSREF_PHASED: begin
        if (rise_i) begin
          count_d  = '0;
          locked_d = 1'b1;
          // Once phased, an edge is expected only where the count would wrap.
          if (locked_q && !at_last) mis_d = 1'b1;
        end else if (locked_q) begin
          count_d = count_inc;
        end else begin
          count_d = '0;
        end
      end
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      locked_q <= 1'b0;
      mis_q    <= 1'b0;
    end else begin
      count_q  <= count_d;
      locked_q <= locked_d;
      mis_q    <= mis_d;
    end
  end

  assign count_o    = count_q;
  assign locked_o   = locked_q;
  assign misalign_o = mis_q;
endmodule

// File: rtl/xmb_boundary_counter.sv
module xmb_boundary_counter
  import xmb_pkg::*;
#(
  parameter int unsigned E_W = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           sysref_i,
  input  logic                           mode_sel_i,
  input  logic [E_W-1:0]                 ext_size_i,
  output logic [E_W+XMB_BLK_SHIFT-1:0]   count_o,
  output logic                           boundary_o,
  output logic                           not_aligned_o,
  output logic                           misalign_o
);
  localparam int unsigned CNT_W = E_W + XMB_BLK_SHIFT;

  logic           sysref_rise;
  logic           cfg_run;
  logic [E_W-1:0] cfg_size;
  xmb_mode_e      cfg_mode;
  logic           locked;

  xmb_sysref_edge #(
    .STAGES(XMB_SYNC_STAGES)
  ) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(sysref_i),
    .rise_o  (sysref_rise)
  );

  xmb_cfg_latch #(
    .E_W(E_W)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_size_i(ext_size_i),
    .mode_i    (xmb_mode_e'(mode_sel_i)),
    .run_o     (cfg_run),
    .ext_size_o(cfg_size),
    .mode_o    (cfg_mode)
  );

  xmb_phase_count #(
    .E_W  (E_W),
    .CNT_W(CNT_W)
  ) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_size_i(cfg_size),
    .mode_i    (cfg_mode),
    .rise_i    (sysref_rise),
    .count_o   (count_o),
    .locked_o  (locked),
    .misalign_o(misalign_o)
  );

  assign not_aligned_o = ~locked;
  assign boundary_o    = cfg_run & locked & (count_o == '0);
endmodule

// File: rtl/xmb_boundary_checker.sv
module xmb_boundary_checker #(
  parameter int unsigned E_W   = 3,
  parameter int unsigned CNT_W = E_W + 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count_o,
  input logic             boundary_o,
  input logic             not_aligned_o,
  input logic             misalign_o,
  input logic             rise,
  input logic             run,
  input logic             phased,
  input logic [E_W-1:0]   size
);
  logic [E_W-1:0]   size_chk;
  logic [CNT_W-1:0] top_chk;

  // Wrap point recomputed from E, independently of the counter.
  always_comb begin
    size_chk = (size == '0) ? E_W'(1) : size;
    top_chk  = CNT_W'(size_chk) * CNT_W'(32) - CNT_W'(1);
  end

  assert_count_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= top_chk);

  assert_wrap_to_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!not_aligned_o && count_o == top_chk && !(phased && rise)) |=> count_o == '0);

  assert_step_by_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!not_aligned_o && count_o != top_chk && !(phased && rise))
      |=> count_o == $past(count_o) + CNT_W'(1));

  assert_hold_unaligned_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    not_aligned_o |-> (count_o == '0 && !boundary_o));

  assert_edge_loads_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phased && rise) |=> (count_o == '0 && !not_aligned_o));

  assert_sticky_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |=> misalign_o);

  assert_cfg_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> ($stable(size) && $stable(phased)));

  assert_free_no_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !phased) |-> !misalign_o);
endmodule

bind xmb_boundary_counter xmb_boundary_checker #(
  .E_W  (E_W),
  .CNT_W(CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .count_o      (count_o),
  .boundary_o   (boundary_o),
  .not_aligned_o(not_aligned_o),
  .misalign_o   (misalign_o),
  .rise         (sysref_rise),
  .run          (cfg_run),
  .phased       (cfg_mode == xmb_pkg::XMB_SYSREF_PHASED),
  .size         (cfg_size)
);

// File: tb/xmb_boundary_counter_test.sv
`timescale 1ns/1ps
module xmb_boundary_counter_test;
  localparam int E_W   = 3;
  localparam int CNT_W = E_W + 5;
  localparam int VEC_N = 7;
  // Each row: E, cycles from alignment to the next SYSREF raise, expected misalign.
  localparam int VECS [VEC_N][3] = '{
    '{1,  29, 0},
    '{1,  61, 0},
    '{2,  61, 0},
    '{2, 125, 0},
    '{3,  93, 0},
    '{2,  29, 1},
    '{1,  10, 1}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             sysref;
  logic             mode;
  logic [E_W-1:0]   e_in;
  logic [CNT_W-1:0] count;
  logic             boundary, nal, mis;
  int               checks = 0;
  int               fails  = 0;
  bit               done   = 1'b0;

  always #2 clk = ~clk;

  xmb_boundary_counter #(.E_W(E_W)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sysref_i     (sysref),
    .mode_sel_i   (mode),
    .ext_size_i   (e_in),
    .count_o      (count),
    .boundary_o   (boundary),
    .not_aligned_o(nal),
    .misalign_o   (mis)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input int e, input bit m);
    rst_n  = 1'b0;
    sysref = 1'b0;
    mode   = m;
    e_in   = E_W'(e);
    step(3);
    chk(count == 0 && nal && !boundary && !mis, "R1 reset state", int'(count), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    int bad;
    int lead, nblk;
    rst_n = 1'b0; sysref = 1'b0; mode = 1'b0; e_in = 3'd2;

    // Free-running mode with E=2; E and SYSREF change during the run.
    do_reset(2, 1'b0);
    step();
    chk(count == 0 && !nal, "R2 first edge after release", int'(count), 0);
    chk(boundary == 1'b1, "R4 boundary at zero", boundary, 1);
    e_in = 3'd1;
    bad = 0;
    for (int i = 1; i <= 63; i++) begin
      sysref = i[2];
      step();
      if (count != CNT_W'(i) || boundary) bad++;
    end
    chk(bad == 0, "R2 steps by one, SYSREF ignored", bad, 0);
    chk(count == 63, "R5 R3 latched E=2 reaches 63", int'(count), 63);
    step();
    chk(count == 0 && boundary, "R3 wrap to zero", int'(count), 0);
    chk(mis == 1'b0, "R2 no misalign in free mode", mis, 0);
    sysref = 1'b0;

    // E of zero behaves as one.
    do_reset(0, 1'b0);
    step(32);
    chk(count == 31, "R3 E=0 top count", int'(count), 31);
    step();
    chk(count == 0, "R3 E=0 wrap", int'(count), 0);

    // Table of SYSREF-phased scenarios.
    for (int v = 0; v < VEC_N; v++) begin
      do_reset(VECS[v][0], 1'b1);
      step();
      mode = 1'b0;
      step(3);
      chk(count == 0 && nal && !boundary, "R6 R5 held before SYSREF", int'(count), 0);
      sysref = 1'b1;
      step(2);
      chk(nal == 1'b1, "R7 not aligned after two edges", nal, 1);
      step();
      chk(count == 0 && !nal && boundary, "R7 aligned on third edge", int'(count), 0);
      sysref = 1'b0;
      lead = VECS[v][1];
      nblk = 32 * VECS[v][0];
      step(lead);
      chk(count == CNT_W'(lead % nblk), "R8 free count before next SYSREF", int'(count), lead % nblk);
      sysref = 1'b1;
      step(3);
      chk(count == 0, "R9 re-phase to zero", int'(count), 0);
      chk(mis == VECS[v][2][0], "R8 R9 misalign flag", mis, VECS[v][2]);
      sysref = 1'b0;
      step(5);
      chk(count == 5, "R9 counting continues", int'(count), 5);
    end

    // Held SYSREF level, then a sticky flag across a later aligned edge.
    do_reset(1, 1'b1);
    sysref = 1'b1;
    step(3);
    chk(!nal && count == 0, "R7 aligned with held SYSREF", int'(count), 0);
    step(40);
    chk(count == 8 && !mis, "R10 held level gives no new edge", int'(count), 8);
    sysref = 1'b0;
    step(2);
    sysref = 1'b1;
    step(3);
    chk(mis == 1'b1 && count == 0, "R9 off-phase edge sets flag", mis, 1);
    sysref = 1'b0;
    step(29);
    sysref = 1'b1;
    step(3);
    chk(mis == 1'b1 && count == 0, "R10 flag stays set after aligned edge", mis, 1);
    sysref = 1'b0;
    do_reset(1, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule